// File: doc/BRIEF.md
# Video Word Clipper and Standard-Aware Blanker

This block conditions a stream of 10-bit video words. It sits after the TRS-blanking stage and ahead of TRS insertion. Its work happens in two steps within one register stage. First, when clipping is enabled, reserved code values inside the active picture are folded into the legal range. Second, a word is replaced with the blanking level of the detected video standard when either of two active-low blank controls asks for it. The controls are a pin and a register bit, and both are sampled on every word.

The blanking level depends on the detected standard. For multiplexed component formats it also depends on the sample phase supplied with each word, so chroma positions and luma or alpha positions receive different levels. When no standard is detected, or the standard code is not one the block recognises, words pass without blanking and a flag reports that the standard is unknown. The block does not guess a level.

Standard codes on `std_code`: 0 = 525-line composite, 1 = 625-line composite, 2 = 4:2:2 component, 3 = 4:4:4:4 in R,G,B,A ordering, 4 = 4:4:4:4 in Cb,Y,Cr,A ordering. Codes 5 to 7 are unrecognised. Sample phase 0..3 on `phase` selects the position within the four-word multiplexed group.

Top module: `vid_word_condition`

## Requirements
- R1: With `clip_en` high, a valid word inside the active picture with value 000h to 003h leaves the block as 004h, unless it is blanked.
- R2: With `clip_en` high, a valid word inside the active picture with value 3FCh to 3FFh leaves the block as 3FBh, unless it is blanked.
- R3: A valid word that is not blanked passes unchanged when `in_active` is low or `clip_en` is low. This holds for reserved values as well.
- R4: A valid word is blanked when `blank_pin_n` is low or `blank_reg_n` is low, provided the standard is known. It passes when both controls are high. The controls act word by word.
- R5: For standard code 2 (4:2:2), the blank level is 200h on phases 0 and 2 and 040h on phases 1 and 3.
- R6: For standard code 0 the blank level is 0F0h. For code 1 it is 100h. Phase is ignored for both.
- R7: For standard code 3 the blank level is 040h on all phases. For code 4 it is 200h on phases 0 and 2 and 040h on phases 1 and 3.
- R8: When `std_locked` is low, or `std_code` is 5 to 7, a valid word is never blanked. Clipping still applies to it, and `std_unknown` is high with that word's output. Otherwise `std_unknown` is low.
- R9: Every output appears exactly one clock after its input word. `out_valid` follows `in_valid` with one cycle of delay. On a cycle with `in_valid` low, `out_word` and `std_unknown` hold their values. After reset the outputs are `out_word`=000h, `out_valid`=0 and `std_unknown`=1.
- R10: Clipping happens before blanking, so a blanked reserved word leaves the block as the blank level and not as the clipped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_word | input | 10 | Incoming video word |
| in_valid | input | 1 | Qualifies `in_word` |
| in_active | input | 1 | High when the word lies in the active picture |
| std_code | input | 3 | Detected standard code (see above) |
| std_locked | input | 1 | High once the standard has been detected |
| phase | input | 2 | Sample position within the four-word multiplexed group |
| clip_en | input | 1 | Enables reserved-value clipping in the active picture |
| blank_pin_n | input | 1 | Active-low blank request from the pin |
| blank_reg_n | input | 1 | Active-low blank request from the register bit |
| out_word | output | 10 | Processed word |
| out_valid | output | 1 | Qualifies `out_word` |
| std_unknown | output | 1 | High when the word was output without blanking because the standard is unknown |

## Verification
Because there is only one register stage, a fault in the level lookup or in the blank gating shows up on `out_word` in the cycle right after the offending word. The fault is tied to the specific standard and phase. For that reason every standard is driven through all four phases. A word register that loads on cycles with `in_valid` low is caught by an idle cycle followed by an unchanged output. An inverted or ORed blank control shows up when exactly one of the two controls is low.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  typedef enum logic [2:0] {
    STD_CMP525 = 3'd0,
    STD_CMP625 = 3'd1,
    STD_C422   = 3'd2,
    STD_RGBA   = 3'd3,
    STD_CBYCRA = 3'd4
  } std_e;

  localparam int unsigned BASE_W = 10;
endpackage

// File: rtl/vwc_clip.sv
module vwc_clip #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] din,
  input  logic         active,
  input  logic         en,
  output logic [W-1:0] dout
);
  localparam int unsigned SH = W - vwc_pkg::BASE_W;
  localparam logic [W-1:0] LOW_LEGAL  = W'(4) << SH;
  localparam logic [W-1:0] HIGH_LEGAL = W'(11'h3FB) << SH;

  always_comb begin
    dout = din;
    if (en && active) begin
      if (din < LOW_LEGAL)       dout = LOW_LEGAL;
      else if (din > HIGH_LEGAL) dout = HIGH_LEGAL;
    end
  end
endmodule

// File: rtl/vwc_blank_level.sv
module vwc_blank_level #(
  parameter int unsigned W = 10
) (
  input  logic [2:0]   std_code,
  input  logic         locked,
  input  logic [1:0]   phase,
  output logic [W-1:0] level,
  output logic         known
);
  import vwc_pkg::*;
  localparam int unsigned SH = W - BASE_W;
  localparam logic [W-1:0] LVL_CHROMA = W'(10'h200) << SH;
  localparam logic [W-1:0] LVL_LUMA   = W'(10'h040) << SH;
  localparam logic [W-1:0] LVL_C525   = W'(10'h0F0) << SH;
  localparam logic [W-1:0] LVL_C625   = W'(10'h100) << SH;

  logic chroma_slot;
  assign chroma_slot = ~phase[0];

  always_comb begin
    level = '0;
    known = locked;
    case (std_e'(std_code))
      STD_CMP525: level = LVL_C525;
      STD_CMP625: level = LVL_C625;
      STD_C422,
      STD_CBYCRA: level = chroma_slot ? LVL_CHROMA : LVL_LUMA;
      STD_RGBA:   level = LVL_LUMA;
      default:    known = 1'b0;
    endcase
  end
endmodule

// File: rtl/vid_word_condition.sv
module vid_word_condition #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  input  logic         in_active,
  input  logic [2:0]   std_code,
  input  logic         std_locked,
  input  logic [1:0]   phase,
  input  logic         clip_en,
  input  logic         blank_pin_n,
  input  logic         blank_reg_n,
  output logic [W-1:0] out_word,
  output logic         out_valid,
  output logic         std_unknown
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  logic [W-1:0] clipped, level;
  logic         known, blank_req;

  vwc_clip #(.W(W)) u_clip (
    .din(in_word), .active(in_active), .en(clip_en), .dout(clipped)
  );

  vwc_blank_level #(.W(W)) u_level (
    .std_code(std_code), .locked(std_locked), .phase(phase),
    .level(level), .known(known)
  );

  assign blank_req = ~(blank_pin_n & blank_reg_n);

  logic [W-1:0] word_q, word_n;
  logic         valid_q, valid_n, unk_q, unk_n, load_en;

  assign load_en = in_valid;

  always_comb begin
    word_n  = word_q;
    unk_n   = unk_q;
    valid_n = in_valid;
    if (load_en) begin
      unk_n  = ~known;
      word_n = (blank_req && known) ? level : clipped;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      unk_q   <= 1'b1;
    end else begin
      word_q  <= word_n;
      valid_q <= valid_n;
      unk_q   <= unk_n;
    end
  end

  assign out_word    = word_q;
  assign out_valid   = valid_q;
  assign std_unknown = unk_q;
endmodule

// File: rtl/vwc_checker.sv
module vwc_checker #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst_q,
  input logic [W-1:0] in_word,
  input logic         in_valid,
  input logic         in_active,
  input logic [2:0]   std_code,
  input logic         std_locked,
  input logic [1:0]   phase,
  input logic         clip_en,
  input logic         blank_pin_n,
  input logic         blank_reg_n,
  input logic [W-1:0] out_word,
  input logic         out_valid,
  input logic         std_unknown
);
  localparam int unsigned SH = W - 10;
  logic std_ok, both_hi;
  assign std_ok  = std_locked && (std_code <= 3'd4);
  assign both_hi = blank_pin_n && blank_reg_n;

  AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && clip_en && in_active && both_hi && in_word < (W'(4) << SH))
    |=> out_word == (W'(4) << SH)); // R1

  AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && clip_en && in_active && both_hi && in_word > (W'(11'h3FB) << SH))
    |=> out_word == (W'(11'h3FB) << SH)); // R2

  AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && both_hi && (!in_active || !clip_en))
    |=> out_word == $past(in_word)); // R3

  AST_RGBA_LEVEL: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && std_locked && std_code == 3'd3 && !both_hi)
    |=> out_word == (W'(10'h040) << SH)); // R7

  AST_UNKNOWN_FLAG: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> std_unknown == !$past(std_ok)); // R8

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> out_valid == $past(in_valid)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(out_word) && $stable(std_unknown))); // R9
endmodule

bind vid_word_condition vwc_checker #(.W(W)) u_vwc_checker (
  .clk(clk), .rst_q(rst_q), .in_word(in_word), .in_valid(in_valid),
  .in_active(in_active), .std_code(std_code), .std_locked(std_locked),
  .phase(phase), .clip_en(clip_en), .blank_pin_n(blank_pin_n),
  .blank_reg_n(blank_reg_n), .out_word(out_word), .out_valid(out_valid),
  .std_unknown(std_unknown)
);

// File: tb/tb_vid_word_condition.sv
module tb_vid_word_condition;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] in_word = '0;
  logic       in_valid = 1'b0, in_active = 1'b0;
  logic [2:0] std_code = 3'd2;
  logic       std_locked = 1'b1;
  logic [1:0] phase = '0;
  logic       clip_en = 1'b0, blank_pin_n = 1'b1, blank_reg_n = 1'b1;
  logic [9:0] out_word;
  logic       out_valid, std_unknown;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  vid_word_condition dut (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_active(in_active), .std_code(std_code), .std_locked(std_locked),
    .phase(phase), .clip_en(clip_en), .blank_pin_n(blank_pin_n),
    .blank_reg_n(blank_reg_n), .out_word(out_word), .out_valid(out_valid),
    .std_unknown(std_unknown)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [9:0] w, input logic act, input logic ce,
                      input logic bp, input logic br, input logic [2:0] sc,
                      input logic [1:0] ph);
    in_word = w; in_valid = 1'b1; in_active = act; clip_en = ce;
    blank_pin_n = bp; blank_reg_n = br; std_code = sc; phase = ph;
    tick();
  endtask

  task automatic t_reset();
    chk("R9 reset word", out_word, 0);
    chk("R9 reset valid", out_valid, 0);
    chk("R9 reset unknown", std_unknown, 1);
  endtask

  task automatic t_clip();
    for (int v = 0; v < 4; v++) begin
      send(10'(v), 1, 1, 1, 1, 3'd2, 2'd0);
      chk("R1 clip low", out_word, 10'h004);
    end
    for (int v = 10'h3FC; v <= 10'h3FF; v++) begin
      send(10'(v), 1, 1, 1, 1, 3'd2, 2'd1);
      chk("R2 clip high", out_word, 10'h3FB);
    end
    send(10'h004, 1, 1, 1, 1, 3'd2, 2'd0);
    chk("R1 legal low kept", out_word, 10'h004);
    send(10'h3FB, 1, 1, 1, 1, 3'd2, 2'd0);
    chk("R2 legal high kept", out_word, 10'h3FB);
  endtask

  task automatic t_pass();
    send(10'h001, 0, 1, 1, 1, 3'd2, 2'd0);
    chk("R3 outside active", out_word, 10'h001);
    send(10'h3FE, 0, 1, 1, 1, 3'd2, 2'd0);
    chk("R3 outside active high", out_word, 10'h3FE);
    send(10'h3FF, 1, 0, 1, 1, 3'd2, 2'd0);
    chk("R3 clip disabled", out_word, 10'h3FF);
    send(10'h155, 1, 1, 1, 1, 3'd2, 2'd0);
    chk("R3 midrange", out_word, 10'h155);
  endtask

  task automatic t_blank_ctrl();
    send(10'h155, 1, 0, 0, 1, 3'd2, 2'd1);
    chk("R4 pin low", out_word, 10'h040);
    send(10'h155, 1, 0, 1, 0, 3'd2, 2'd1);
    chk("R4 reg low", out_word, 10'h040);
    send(10'h155, 1, 0, 0, 0, 3'd2, 2'd0);
    chk("R4 both low", out_word, 10'h200);
    send(10'h155, 1, 0, 1, 1, 3'd2, 2'd0);
    chk("R4 both high", out_word, 10'h155);
  endtask

  task automatic t_422();
    for (int p = 0; p < 4; p++) begin
      send(10'h2AA, 1, 0, 0, 1, 3'd2, 2'(p));
      chk("R5 422 level", out_word, (p % 2 == 0) ? 10'h200 : 10'h040);
    end
  endtask

  task automatic t_composite();
    for (int p = 0; p < 4; p++) begin
      send(10'h2AA, 1, 0, 1, 0, 3'd0, 2'(p));
      chk("R6 525 level", out_word, 10'h0F0);
      send(10'h2AA, 1, 0, 1, 0, 3'd1, 2'(p));
      chk("R6 625 level", out_word, 10'h100);
    end
  endtask

  task automatic t_444();
    for (int p = 0; p < 4; p++) begin
      send(10'h2AA, 1, 0, 0, 1, 3'd3, 2'(p));
      chk("R7 rgba level", out_word, 10'h040);
      send(10'h2AA, 1, 0, 0, 1, 3'd4, 2'(p));
      chk("R7 cbycra level", out_word, (p % 2 == 0) ? 10'h200 : 10'h040);
    end
  endtask

  task automatic t_unknown();
    send(10'h123, 1, 0, 0, 1, 3'd2, 2'd0);
    chk("R8 locked flag", std_unknown, 0);
    std_locked = 1'b0;
    send(10'h123, 1, 0, 0, 0, 3'd2, 2'd0);
    chk("R8 unlocked pass", out_word, 10'h123);
    chk("R8 unlocked flag", std_unknown, 1);
    send(10'h3FF, 1, 1, 0, 0, 3'd2, 2'd0);
    chk("R8 unlocked still clips", out_word, 10'h3FB);
    std_locked = 1'b1;
    send(10'h0AB, 1, 0, 0, 1, 3'd6, 2'd0);
    chk("R8 bad code pass", out_word, 10'h0AB);
    chk("R8 bad code flag", std_unknown, 1);
    send(10'h0AB, 1, 0, 0, 1, 3'd1, 2'd0);
    chk("R8 recover flag", std_unknown, 0);
  endtask

  task automatic t_timing();
    in_valid = 1'b0; in_word = 10'h111;
    tick();
    chk("R9 valid drops", out_valid, 0);
    chk("R9 word held", out_word, 10'h100);
    send(10'h0AB, 1, 0, 1, 1, 3'd1, 2'd0);
    chk("R9 valid rises", out_valid, 1);
    in_word = 10'h3CC; in_valid = 1'b1; blank_pin_n = 1'b1; blank_reg_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R9 one-cycle latency", out_word, 10'h3CC);
    @(negedge clk);
    std_locked = 1'b0; in_valid = 1'b0;
    tick();
    chk("R9 flag held idle", std_unknown, 0);
    std_locked = 1'b1;
  endtask

  task automatic t_order();
    send(10'h3FE, 1, 1, 0, 1, 3'd2, 2'd0);
    chk("R10 blank over clip", out_word, 10'h200);
    send(10'h002, 1, 1, 1, 0, 3'd0, 2'd0);
    chk("R10 blank over clip low", out_word, 10'h0F0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clip();
    t_pass();
    t_blank_ctrl();
    t_422();
    t_composite();
    t_444();
    t_unknown();
    t_timing();
    t_order();
    summary();
    $finish;
  end
endmodule